// File: doc/BRIEF.md
# Multi-Channel Two-Stage PWM Generator

The block drives four independent active-high PWM outputs from one input clock. Each channel divides the clock in two stages. A prescaler first counts input cycles. A period counter then advances once every time the prescaler wraps. The output is high while the period counter is below a programmed high-duration value. A channel's period is therefore (prescale+1)×(divider+1) input cycles, and its high time is high-duration×(prescale+1) input cycles. A high-duration value above the divider holds the output permanently high.

Software programs the channels through a 32-bit write/read port. Each channel owns an 8-byte slot holding two words. The first word carries the high-duration count and the period divider. The second word carries the prescale value, an enable flag and a commit flag. All writes land in shadow fields, and reads return those shadow fields. Writing the second word with the commit flag set hands the shadow fields to the counting logic. A disabled channel picks them up on the following cycle. A running channel picks them up at its next period boundary, so a period is never cut short.

Each channel is controlled by a three-state machine with these states:
- `ST_OFF`: idle, output low, both counters at zero.
- `ST_RUN`: counting.
- `ST_PEND`: counting, with a commit waiting for the period boundary.

The transitions are:
- `OFF→RUN`: a commit with enable set.
- `OFF→OFF`: a commit with enable clear.
- `RUN→PEND`: any commit.
- `PEND→RUN`: the boundary is reached with enable set.
- `PEND→OFF`: the boundary is reached with enable clear.

Top module: `pwmx_bank`

## Requirements
- R1: A word's byte address is 8×channel + 4×word, where word 0 is the timing word and word 1 is the control word; address bits [1:0] are ignored. In the timing word, bits [15:0] hold the high-duration count and bits [31:16] hold the period divider. In the control word, bits [15:0] hold the prescale value, bit 30 is commit and bit 31 is enable.
- R2: Reading a word returns the last written shadow fields, with all unused bits and the commit bit (bit 30) reading as 0.
- R3: A running channel repeats with a period of (prescale+1)×(divider+1) input clock cycles.
- R4: Each period starts with the output high for high-duration×(prescale+1) cycles, after which the output is low for the rest of the period.
- R5: A high-duration value of 0 gives a constant-low output. A value greater than the divider gives a constant-high output.
- R6: Writing a word without the commit bit changes nothing at the output.
- R7: A commit issued to a disabled channel with enable set starts the channel two clock edges after the write edge, at the first count of a new period.
- R8: A commit issued to a running channel takes effect exactly at the next period boundary; until that boundary the old settings stay in force.
- R9: A commit with enable clear stops the channel at the next period boundary. From then on the output stays low.
- R10: Writes to one channel leave every other channel's output unchanged.
- R11: After reset, all outputs are low and all words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the accessed word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr`, combinational |
| pwm_out | output | 4 | One active-high PWM output per channel |

## Verification
A counter that loads or wraps at the wrong value changes the output at a specific input cycle. That error shows within the first period after a commit. To catch it, the checks compare every cycle of the output against the arithmetic pattern rather than only averages. A wrong state in the commit machine would either cut a period short or start a channel one cycle early or late. Such errors show within one period and are caught by checking the exact edge counted from the write. A decode that points at the wrong slot lights or silences a different channel at once.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
    localparam int WORD_W    = 32;
    localparam int FIELD_HI  = 16;
    localparam int BIT_EN    = 31;
    localparam int BIT_COMMIT = 30;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } chan_state_e;
endpackage

// File: rtl/pwmx_shadow.sv
module pwmx_shadow
    import pwmx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_timing,
    input  logic              wr_ctrl,
    input  logic [WORD_W-1:0] wdata,
    output logic [DW-1:0]     sh_hi,
    output logic [DW-1:0]     sh_div,
    output logic [DW-1:0]     sh_pre,
    output logic              sh_en,
    output logic              commit,
    output logic [WORD_W-1:0] rd_timing,
    output logic [WORD_W-1:0] rd_ctrl
);
    // Shadow fields: written by software, read back, copied on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hi  <= '0;
            sh_div <= '0;
            sh_pre <= '0;
            sh_en  <= 1'b0;
            commit <= 1'b0;
        end else begin
            if (wr_timing) begin
                sh_hi  <= wdata[DW-1:0];
                sh_div <= wdata[FIELD_HI +: DW];
            end
            if (wr_ctrl) begin
                sh_pre <= wdata[DW-1:0];
                sh_en  <= wdata[BIT_EN];
            end
            commit <= wr_ctrl && wdata[BIT_COMMIT];
        end
    end

    // Readback: commit bit never stored, so it reads 0
    always_comb begin
        rd_timing = '0;
        rd_timing[DW-1:0]        = sh_hi;
        rd_timing[FIELD_HI +: DW] = sh_div;
        rd_ctrl = '0;
        rd_ctrl[DW-1:0] = sh_pre;
        rd_ctrl[BIT_EN] = sh_en;
    end
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [DW-1:0] sh_hi,
    input  logic [DW-1:0] sh_div,
    input  logic [DW-1:0] sh_pre,
    input  logic          sh_en,
    output logic          pwm_o
);
    chan_state_e   state_q, state_d;
    logic [DW-1:0] hi_act, div_act, pre_act;
    logic [DW-1:0] pre_cnt, per_cnt;
    logic          pre_wrap, per_wrap, load;

    assign pre_wrap = (pre_cnt == pre_act);
    assign per_wrap = pre_wrap && (per_cnt == div_act);
    assign load     = ((state_q == ST_OFF) && commit) ||
                      ((state_q == ST_PEND) && per_wrap);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (commit)   state_d = sh_en ? ST_RUN : ST_OFF;
            ST_RUN:  if (commit)   state_d = ST_PEND;
            ST_PEND: if (per_wrap) state_d = sh_en ? ST_RUN : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Active settings, copied from the shadow fields on load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_act  <= '0;
            div_act <= '0;
            pre_act <= '0;
        end else if (load) begin
            hi_act  <= sh_hi;
            div_act <= sh_div;
            pre_act <= sh_pre;
        end
    end

    // Two-stage counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (load || state_q == ST_OFF) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            per_cnt <= per_wrap ? '0 : per_cnt + DW'(1);
        end else begin
            pre_cnt <= pre_cnt + DW'(1);
        end
    end

    // Output
    always_comb begin
        pwm_o = (state_q != ST_OFF) && (per_cnt < hi_act);
    end

    p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |-> (pre_cnt <= pre_act));
    p_per_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |-> (per_cnt <= div_act));
    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (pre_cnt == '0 && per_cnt == '0 && !pwm_o));
    p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && hi_act > div_act) |-> pwm_o);
    p_boundary_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && per_wrap) |=> (pre_cnt == '0 && per_cnt == '0));
    p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !per_wrap) |=>
            ($stable(hi_act) && $stable(div_act) && $stable(pre_act)));
endmodule

// File: rtl/pwmx_bank.sv
module pwmx_bank
    import pwmx_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int DW  = 16,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW  = CW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [CW-1:0]     ch_idx;
    logic              sel_ctrl;
    logic              unused_addr_bits;
    logic [WORD_W-1:0] rd_timing [NCH];
    logic [WORD_W-1:0] rd_ctrl   [NCH];

    assign ch_idx           = bus_addr[AW-1:3];
    assign sel_ctrl         = bus_addr[2];
    assign unused_addr_bits = ^bus_addr[1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic          hit;
        logic [DW-1:0] sh_hi, sh_div, sh_pre;
        logic          sh_en, commit;

        assign hit = bus_wr && (ch_idx == CW'(g));

        pwmx_shadow #(.DW(DW)) i_shadow (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_timing (hit && !sel_ctrl),
            .wr_ctrl   (hit && sel_ctrl),
            .wdata     (bus_wdata),
            .sh_hi     (sh_hi),
            .sh_div    (sh_div),
            .sh_pre    (sh_pre),
            .sh_en     (sh_en),
            .commit    (commit),
            .rd_timing (rd_timing[g]),
            .rd_ctrl   (rd_ctrl[g])
        );

        pwmx_chan #(.DW(DW)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (commit),
            .sh_hi  (sh_hi),
            .sh_div (sh_div),
            .sh_pre (sh_pre),
            .sh_en  (sh_en),
            .pwm_o  (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_idx == CW'(i))
                bus_rdata = sel_ctrl ? rd_ctrl[i] : rd_timing[i];
        end
    end

    p_commit_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> !bus_rdata[BIT_COMMIT]);
endmodule

// File: tb/test_pwmx_bank.sv
module test_pwmx_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwmx_bank i_pwmx_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int ch, input int w, input logic [31:0] d);
        bus_addr  = 5'(ch * 8 + w * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int ch, input int w, output logic [31:0] d);
        bus_addr = 5'(ch * 8 + w * 4);
        #1;
        d = bus_rdata;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11 reset state
        chk(pwm_out == 4'b0, "R11", "outputs after reset", pwm_out, 0);
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 2; w++) begin
                rd(c, w, d);
                chk(d == 32'h0, "R11", "word after reset", d, 0);
            end

        // R1 / R2 readback on channel 1
        wr(1, 0, 32'h0003_0002);
        wr(1, 1, 32'h8000_0002);
        rd(1, 0, d); chk(d == 32'h0003_0002, "R1", "ch1 timing word", d, 32'h0003_0002);
        rd(1, 1, d); chk(d == 32'h8000_0002, "R1", "ch1 control word", d, 32'h8000_0002);
        rd(0, 0, d); chk(d == 32'h0, "R1", "ch0 untouched by ch1 write", d, 0);
        repeat (3) tick();
        chk(pwm_out == 4'b0, "R6", "enable without commit", pwm_out, 0);
        wr(1, 1, 32'hC000_0002);
        chk(pwm_out == 4'b0, "R7", "output one edge after commit", pwm_out, 0);
        rd(1, 1, d); chk(d == 32'h8000_0002, "R2", "commit reads 0", d, 32'h8000_0002);
        tick();
        chk(pwm_out == 4'b0010, "R7", "ch1 starts two edges after commit", pwm_out, 4'b0010);
        wr(1, 1, 32'h4000_0002);
        repeat (20) tick();
        chk(pwm_out == 4'b0, "R9", "ch1 stopped", pwm_out, 0);

        // R3 R4 R5 sweep on channel 0
        for (int pre = 0; pre < 3; pre++)
            for (int dv = 0; dv < 4; dv++)
                for (int hi = 0; hi < 6; hi++) begin
                    int per_len, bad, first_k;
                    string req;
                    wr(0, 1, 32'h4000_0000);
                    repeat (14) tick();
                    chk(pwm_out[0] == 1'b0, "R9", "ch0 stopped before config", pwm_out[0], 0);
                    wr(0, 0, (32'(dv) << 16) | 32'(hi));
                    wr(0, 1, 32'hC000_0000 | 32'(pre));
                    tick();
                    per_len = (pre + 1) * (dv + 1);
                    bad = 0; first_k = -1;
                    for (int k = 0; k < 2 * per_len + 2; k++) begin
                        bit e;
                        e = (((k / (pre + 1)) % (dv + 1)) < hi);
                        if (pwm_out[0] != e) begin
                            bad++;
                            if (first_k < 0) first_k = k;
                        end
                        tick();
                    end
                    if (hi == 0 || hi > dv) req = "R5";
                    else                    req = "R4";
                    chk(bad == 0,
                        req, $sformatf("R3 pattern pre=%0d div=%0d hi=%0d first_bad_cycle=%0d",
                                       pre, dv, hi, first_k), bad, 0);
                end

        // R6 / R8 deferred commit on channel 0
        wr(0, 1, 32'h4000_0000);
        repeat (14) tick();
        wr(0, 0, 32'h0003_0001);
        wr(0, 1, 32'hC000_0001);
        tick();                 // k = 0
        tick(); tick();         // k = 2
        wr(0, 0, 32'h0003_0003); // returns at k = 3
        chk(pwm_out[0] == 1'b0, "R6", "timing write without commit k=3", pwm_out[0], 0);
        wr(0, 1, 32'hC000_0001); // returns at k = 4
        for (int k = 4; k < 16; k++) begin
            bit e;
            e = (k >= 8 && k <= 13);
            chk(pwm_out[0] == e, "R8", $sformatf("deferred commit cycle %0d", k), pwm_out[0], e);
            tick();
        end
        // R9 stop at boundary: now at the first cycle of a new period
        wr(0, 1, 32'h4000_0001); // returns at cycle 1 of the period
        for (int k = 1; k <= 20; k++) begin
            bit e;
            e = (k <= 5);
            chk(pwm_out[0] == e, "R9", $sformatf("stop at boundary cycle %0d", k), pwm_out[0], e);
            tick();
        end

        // R10 channel independence
        wr(2, 0, 32'h0001_0001);
        wr(2, 1, 32'hC000_0000);
        tick();
        begin
            int highs2, others;
            highs2 = 0; others = 0;
            for (int k = 0; k < 10; k++) begin
                highs2 += int'(pwm_out[2]);
                others += int'(pwm_out[0]) + int'(pwm_out[1]) + int'(pwm_out[3]);
                tick();
            end
            chk(highs2 == 5, "R10", "ch2 high count", highs2, 5);
            chk(others == 0, "R10", "other channels high count", others, 0);
        end
        report();
    end
endmodule